// File: doc/BRIEF.md
# DMA Channel Major-Loop Completion Control

This block is the per-channel sequencing logic of a multi-channel DMA engine. It keeps a begin count and a current count of major iterations. On every activation strobe from the engine (one finished minor loop) it counts the current value down. It can raise a halfway interrupt request, and when the count reaches zero it completes the major loop. Completion can raise an interrupt request, ask the request-enable logic to turn off the channel's hardware request, start a linked channel and request a descriptor reload from memory.

Software programs the channel through a single write port. The port has three targets: a control word, a count word and a descriptor pointer. The channel start bit is set by software or by a link from another channel. It is handed to the engine as a one-cycle go strobe once the engine is idle. While the done flag is set, the link and reload enables cannot be written to one. The descriptor reload is modelled as an address held with a request until the fetch side acknowledges it. A misaligned pointer gives an error pulse and no fetch.

Top module: `dma_major_ctl`

## Requirements
- R1: After reset the done flag is low, `citer_o` is 1, every strobe output is low, `sg_req_o` is low and `en_link_o`/`en_sg_o` are low.
- R2: A write with `wr_sel`=1 loads the begin count and the current count from `wr_data[14:0]`, with 0 loaded as 1, and clears the done flag. An activation in that same cycle is ignored.
- R3: Each accepted activation that does not complete the loop lowers `citer_o` by one. `citer_o` always stays between 1 and the begin count.
- R4: When control bit 2 (half enable) is set, `irq_half_o` pulses for one cycle after an activation whose decremented count equals the begin count shifted right by one. This includes a begin count of 1, where one activation gives both the half and the completion pulse.
- R5: An activation whose decremented count is zero completes the loop. It sets the done flag and reloads `citer_o` from the begin count. If control bit 1 is set, `irq_maj_o` pulses for one cycle.
- R6: At completion with control bit 3 set, `req_dis_o` pulses for one cycle. Otherwise it stays low.
- R7: At completion with control bit 5 set, `link_start_o` pulses for exactly one cycle and `link_ch_o` carries control bits [13:8] as held before that cycle.
- R8: At completion with control bit 4 set and a pointer (write `wr_sel`=2) whose low five bits are zero, `sg_req_o` rises with `sg_addr_o` equal to the pointer. It stays high until the cycle after `sg_ack_i` is sampled high. A new completion in the acknowledge cycle keeps it high.
- R9: At completion with control bit 4 set and a nonzero low five pointer bits, `sg_err_o` pulses for one cycle and `sg_req_o` is not raised.
- R10: Writing control bit 0 as one, or pulsing `link_in_i`, sets the start bit. `start_go_o` is high while the start bit is set and `eng_busy_i` is low. The go cycle clears the start bit unless a new set arrives in it, and it also clears the done flag unless a completion happens in the same cycle.
- R11: A control write (`wr_sel`=0) stores bits 4 and 5 as zero when the done flag is set before that cycle, and as written otherwise. `en_sg_o` and `en_link_o` show the stored bits.
- R12: An accepted activation that does not complete the loop clears the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 count, 2 descriptor pointer |
| wr_data | input | 32 | Write data |
| act_i | input | 1 | Minor-loop activation finished |
| eng_busy_i | input | 1 | Engine busy, holds back the go strobe |
| link_in_i | input | 1 | Start request linked from another channel |
| sg_ack_i | input | 1 | Descriptor fetch accepted |
| irq_half_o | output | 1 | Halfway interrupt request pulse |
| irq_maj_o | output | 1 | Completion interrupt request pulse |
| req_dis_o | output | 1 | Clear hardware request enable pulse |
| link_start_o | output | 1 | Start linked channel pulse |
| link_ch_o | output | 6 | Linked channel index |
| start_go_o | output | 1 | Channel begins execution |
| sg_req_o | output | 1 | Descriptor fetch request |
| sg_addr_o | output | 32 | Descriptor fetch address |
| sg_err_o | output | 1 | Misaligned descriptor pointer pulse |
| done_o | output | 1 | Major loop done flag |
| citer_o | output | 15 | Current major count |
| en_link_o | output | 1 | Stored link enable |
| en_sg_o | output | 1 | Stored reload enable |

## Verification
The sharpest overlap is a control write landing in the same cycle as the completing activation. The write must still store the link and reload enables, because the done flag only rises at that edge, and the very next control write must see them masked to zero. The bench drives both in one cycle and then reads `en_link_o`/`en_sg_o` twice. A second overlap is a count write on top of an activation, judged by `citer_o` and the absence of pulses. A reference model stepped every clock also meets random mixes of writes, activations, links and acknowledges, so it also covers go-versus-completion and acknowledge-versus-new-request collisions.

// File: rtl/dma_major_pkg.sv
`timescale 1ns/1ps
package dma_major_pkg;

  // control word bit positions
  localparam int unsigned CB_START    = 0;
  localparam int unsigned CB_INT_MAJ  = 1;
  localparam int unsigned CB_INT_HALF = 2;
  localparam int unsigned CB_DREQ     = 3;
  localparam int unsigned CB_ESG      = 4;
  localparam int unsigned CB_ELINK    = 5;
  localparam int unsigned CB_LINK_LSB = 8;

  typedef enum logic [1:0] {
    WS_CTRL  = 2'd0,
    WS_COUNT = 2'd1,
    WS_SGPTR = 2'd2,
    WS_RSVD  = 2'd3
  } wsel_e;

  typedef struct packed {
    logic int_maj;
    logic int_half;
    logic d_req;
    logic e_sg;
    logic e_link;
  } ctl_flags_t;

endpackage

// File: rtl/dma_ctl_regs.sv
`timescale 1ns/1ps
module dma_ctl_regs
  import dma_major_pkg::*;
#(
  parameter int unsigned LINK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_i,
  input  ctl_flags_t        flags_i,
  input  logic [LINK_W-1:0] link_ch_i,
  input  logic              start_bit_i,
  input  logic              link_in_i,
  input  logic              eng_busy_i,
  input  logic              done_i,
  output ctl_flags_t        flags_o,
  output logic [LINK_W-1:0] link_ch_o,
  output logic              start_go_o
);

  ctl_flags_t        flags_q;
  logic [LINK_W-1:0] link_ch_q;
  logic              start_q;
  logic              start_set;
  logic              start_go;

  assign start_set = (ctl_wr_i && start_bit_i) || link_in_i;
  assign start_go  = start_q && !eng_busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q   <= '0;
      link_ch_q <= '0;
    end else if (ctl_wr_i) begin
      flags_q.int_maj  <= flags_i.int_maj;
      flags_q.int_half <= flags_i.int_half;
      flags_q.d_req    <= flags_i.d_req;
      // coherency guard: no arming of link or reload while done
      flags_q.e_sg     <= flags_i.e_sg   && !done_i;
      flags_q.e_link   <= flags_i.e_link && !done_i;
      link_ch_q        <= link_ch_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_set || (start_q && !start_go);
  end

  assign flags_o    = flags_q;
  assign link_ch_o  = link_ch_q;
  assign start_go_o = start_go;

endmodule

// File: rtl/dma_iter_cnt.sv
`timescale 1ns/1ps
module dma_iter_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_data_i,
  input  logic             act_i,
  input  logic             start_go_i,
  output logic [CNT_W-1:0] citer_o,
  output logic [CNT_W-1:0] biter_o,
  output logic             done_o,
  output logic             evt_act_o,
  output logic             evt_cmp_o,
  output logic             evt_half_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] eff_begin(input logic [CNT_W-1:0] raw);
    return (raw == '0) ? ONE : raw;
  endfunction

  function automatic logic [CNT_W-1:0] half_mark(input logic [CNT_W-1:0] b);
    return b >> 1;
  endfunction

  logic [CNT_W-1:0] citer_q, biter_q, next_cnt;
  logic             done_q, act_ok, cmp, half_hit;

  assign act_ok   = act_i && !cnt_wr_i;
  assign next_cnt = citer_q - ONE;
  assign cmp      = act_ok && (next_cnt == '0);
  assign half_hit = act_ok && (next_cnt == half_mark(biter_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      citer_q <= ONE;
      biter_q <= ONE;
      done_q  <= 1'b0;
    end else if (cnt_wr_i) begin
      biter_q <= eff_begin(cnt_data_i);
      citer_q <= eff_begin(cnt_data_i);
      done_q  <= 1'b0;
    end else if (cmp) begin
      citer_q <= biter_q;
      done_q  <= 1'b1;
    end else begin
      if (act_ok) citer_q <= next_cnt;
      if (act_ok || start_go_i) done_q <= 1'b0;
    end
  end

  assign citer_o    = citer_q;
  assign biter_o    = biter_q;
  assign done_o     = done_q;
  assign evt_act_o  = act_ok;
  assign evt_cmp_o  = cmp;
  assign evt_half_o = half_hit;

endmodule

// File: rtl/dma_sg_fetch.sv
`timescale 1ns/1ps
module dma_sg_fetch #(
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr_i,
  input  logic [AW-1:0] ptr_data_i,
  input  logic          fire_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          err_o
);

  function automatic logic is_aligned(input logic [AW-1:0] p);
    return p[ALIGN_W-1:0] == '0;
  endfunction

  logic [AW-1:0] ptr_q, addr_q;
  logic          req_q, err_q, ok;

  assign ok = is_aligned(ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_wr_i) ptr_q <= ptr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= fire_i && !ok;
      if (fire_i && ok) begin
        req_q  <= 1'b1;
        addr_q <= ptr_q;
      end else if (ack_i) begin
        req_q <= 1'b0;
      end
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign err_o  = err_q;

endmodule

// File: rtl/dma_major_ctl.sv
`timescale 1ns/1ps
module dma_major_ctl
  import dma_major_pkg::*;
#(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned LINK_W  = 6,
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [AW-1:0]     wr_data,
  input  logic              act_i,
  input  logic              eng_busy_i,
  input  logic              link_in_i,
  input  logic              sg_ack_i,
  output logic              irq_half_o,
  output logic              irq_maj_o,
  output logic              req_dis_o,
  output logic              link_start_o,
  output logic [LINK_W-1:0] link_ch_o,
  output logic              start_go_o,
  output logic              sg_req_o,
  output logic [AW-1:0]     sg_addr_o,
  output logic              sg_err_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  citer_o,
  output logic              en_link_o,
  output logic              en_sg_o
);

  wsel_e sel;
  logic  ctl_wr, cnt_wr, ptr_wr;

  assign sel    = wsel_e'(wr_sel);
  assign ctl_wr = wr_en && (sel == WS_CTRL);
  assign cnt_wr = wr_en && (sel == WS_COUNT);
  assign ptr_wr = wr_en && (sel == WS_SGPTR);

  ctl_flags_t        flags_wr, flags;
  logic [LINK_W-1:0] link_ch_w;
  logic              start_go, done_w;
  logic [CNT_W-1:0]  biter_w;
  logic              evt_act, evt_cmp, evt_half, evt_sg_fire;

  assign flags_wr.int_maj  = wr_data[CB_INT_MAJ];
  assign flags_wr.int_half = wr_data[CB_INT_HALF];
  assign flags_wr.d_req    = wr_data[CB_DREQ];
  assign flags_wr.e_sg     = wr_data[CB_ESG];
  assign flags_wr.e_link   = wr_data[CB_ELINK];

  dma_ctl_regs #(.LINK_W(LINK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_i   (ctl_wr),
    .flags_i    (flags_wr),
    .link_ch_i  (wr_data[CB_LINK_LSB +: LINK_W]),
    .start_bit_i(wr_data[CB_START]),
    .link_in_i  (link_in_i),
    .eng_busy_i (eng_busy_i),
    .done_i     (done_w),
    .flags_o    (flags),
    .link_ch_o  (link_ch_w),
    .start_go_o (start_go)
  );

  dma_iter_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr_i  (cnt_wr),
    .cnt_data_i(wr_data[CNT_W-1:0]),
    .act_i     (act_i),
    .start_go_i(start_go),
    .citer_o   (citer_o),
    .biter_o   (biter_w),
    .done_o    (done_w),
    .evt_act_o (evt_act),
    .evt_cmp_o (evt_cmp),
    .evt_half_o(evt_half)
  );

  assign evt_sg_fire = evt_cmp && flags.e_sg;

  dma_sg_fetch #(.AW(AW), .ALIGN_W(ALIGN_W)) u_sg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_wr_i  (ptr_wr),
    .ptr_data_i(wr_data),
    .fire_i    (evt_sg_fire),
    .ack_i     (sg_ack_i),
    .req_o     (sg_req_o),
    .addr_o    (sg_addr_o),
    .err_o     (sg_err_o)
  );

  // completion and progress strobes, one register stage
  logic              half_q, maj_q, dis_q, link_q;
  logic [LINK_W-1:0] link_ch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      maj_q     <= 1'b0;
      dis_q     <= 1'b0;
      link_q    <= 1'b0;
      link_ch_q <= '0;
    end else begin
      half_q <= evt_half && flags.int_half;
      maj_q  <= evt_cmp && flags.int_maj;
      dis_q  <= evt_cmp && flags.d_req;
      link_q <= evt_cmp && flags.e_link;
      if (evt_cmp && flags.e_link) link_ch_q <= link_ch_w;
    end
  end

  assign irq_half_o   = half_q;
  assign irq_maj_o    = maj_q;
  assign req_dis_o    = dis_q;
  assign link_start_o = link_q;
  assign link_ch_o    = link_ch_q;
  assign start_go_o   = start_go;
  assign done_o       = done_w;
  assign en_link_o    = flags.e_link;
  assign en_sg_o      = flags.e_sg;

endmodule

// File: rtl/dma_major_ctl_chk.sv
`timescale 1ns/1ps
module dma_major_ctl_chk #(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             act_i,
  input logic             link_in_i,
  input logic             sg_ack_i,
  input logic             irq_half_o,
  input logic             irq_maj_o,
  input logic             req_dis_o,
  input logic             link_start_o,
  input logic             start_go_o,
  input logic             sg_req_o,
  input logic [AW-1:0]    sg_addr_o,
  input logic             sg_err_o,
  input logic             done_o,
  input logic [CNT_W-1:0] citer_o,
  input logic [CNT_W-1:0] biter,
  input logic             en_link_o,
  input logic             en_sg_o
);

  logic ctl_wr, cnt_wr;
  assign ctl_wr = wr_en && (wr_sel == 2'd0);
  assign cnt_wr = wr_en && (wr_sel == 2'd1);

  AST_CITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (citer_o != '0) && (citer_o <= biter));  // R3
  AST_HALF_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half_o |-> $past(act_i));  // R4
  AST_MAJ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_maj_o |-> done_o);  // R5
  AST_DIS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_dis_o |-> done_o);  // R6
  AST_LINK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    link_start_o |-> done_o);  // R7
  AST_SG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_req_o && !sg_ack_i) |=> sg_req_o);  // R8
  AST_SG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    sg_req_o |-> (sg_addr_o[ALIGN_W-1:0] == '0));  // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sg_err_o |-> done_o);  // R9
  AST_GO_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go_o && !ctl_wr && !link_in_i) |=> !start_go_o);  // R10
  AST_MASK_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && done_o) |=> (!en_link_o && !en_sg_o));  // R11
  AST_ACT_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && !cnt_wr && (citer_o != 1)) |=> !done_o);  // R12

endmodule

bind dma_major_ctl dma_major_ctl_chk #(.CNT_W(CNT_W), .AW(AW), .ALIGN_W(ALIGN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .act_i       (act_i),
  .link_in_i   (link_in_i),
  .sg_ack_i    (sg_ack_i),
  .irq_half_o  (irq_half_o),
  .irq_maj_o   (irq_maj_o),
  .req_dis_o   (req_dis_o),
  .link_start_o(link_start_o),
  .start_go_o  (start_go_o),
  .sg_req_o    (sg_req_o),
  .sg_addr_o   (sg_addr_o),
  .sg_err_o    (sg_err_o),
  .done_o      (done_o),
  .citer_o     (citer_o),
  .biter       (biter_w),
  .en_link_o   (en_link_o),
  .en_sg_o     (en_sg_o)
);

// File: tb/dma_major_ctl_tb.sv
`timescale 1ns/1ps
module dma_major_ctl_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wr_en, act_i, eng_busy_i, link_in_i, sg_ack_i;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        irq_half_o, irq_maj_o, req_dis_o, link_start_o, start_go_o;
  logic        sg_req_o, sg_err_o, done_o, en_link_o, en_sg_o;
  logic [5:0]  link_ch_o;
  logic [31:0] sg_addr_o;
  logic [14:0] citer_o;

  dma_major_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .act_i(act_i), .eng_busy_i(eng_busy_i), .link_in_i(link_in_i), .sg_ack_i(sg_ack_i),
    .irq_half_o(irq_half_o), .irq_maj_o(irq_maj_o), .req_dis_o(req_dis_o),
    .link_start_o(link_start_o), .link_ch_o(link_ch_o), .start_go_o(start_go_o),
    .sg_req_o(sg_req_o), .sg_addr_o(sg_addr_o), .sg_err_o(sg_err_o),
    .done_o(done_o), .citer_o(citer_o), .en_link_o(en_link_o), .en_sg_o(en_sg_o)
  );

  int  n_run = 0, n_fail = 0;
  bit  finished = 0;

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int     m_biter, m_citer, m_lch, p_lch;
  bit     m_done, m_start, m_im, m_ih, m_dr, m_es, m_el;
  longint m_ptr, m_addr;
  bit     m_req, m_err, p_half, p_maj, p_dis, p_link;

  always @(posedge clk) begin : model
    bit cw, nw, pw, go, aok, cmp, fire, old_done;
    int nc, b;
    if (!rst_n) begin
      m_biter = 1; m_citer = 1; m_lch = 0; p_lch = 0;
      m_done = 0; m_start = 0; m_im = 0; m_ih = 0; m_dr = 0; m_es = 0; m_el = 0;
      m_ptr = 0; m_addr = 0; m_req = 0; m_err = 0;
      p_half = 0; p_maj = 0; p_dis = 0; p_link = 0;
    end else begin
      cw  = wr_en && wr_sel == 2'd0;
      nw  = wr_en && wr_sel == 2'd1;
      pw  = wr_en && wr_sel == 2'd2;
      go  = m_start && !eng_busy_i;
      aok = act_i && !nw;
      nc  = m_citer - 1;
      cmp = aok && nc == 0;
      p_half = aok && m_ih && (nc == m_biter / 2);
      p_maj  = cmp && m_im;
      p_dis  = cmp && m_dr;
      p_link = cmp && m_el;
      if (p_link) p_lch = m_lch;
      fire  = cmp && m_es;
      m_err = fire && (m_ptr % 32 != 0);
      if (fire && (m_ptr % 32 == 0)) begin
        m_req = 1; m_addr = m_ptr;
      end else if (sg_ack_i) m_req = 0;
      old_done = m_done;
      if (nw) begin
        b = int'(wr_data[14:0]);
        if (b == 0) b = 1;
        m_biter = b; m_citer = b; m_done = 0;
      end else if (cmp) begin
        m_citer = m_biter; m_done = 1;
      end else begin
        if (aok) m_citer = nc;
        if (aok || go) m_done = 0;
      end
      if (cw) begin
        m_im = wr_data[1]; m_ih = wr_data[2]; m_dr = wr_data[3];
        m_es = wr_data[4] && !old_done;
        m_el = wr_data[5] && !old_done;
        m_lch = int'(wr_data[13:8]);
      end
      m_start = (cw && wr_data[0]) || link_in_i || (m_start && !go);
      if (pw) m_ptr = longint'(wr_data);
    end
  end

  always @(negedge clk) begin : compare
    if (rst_n && !finished) begin
      chk("R3",  "citer_o",      citer_o,      m_citer);
      chk("R4",  "irq_half_o",   irq_half_o,   p_half);
      chk("R5",  "irq_maj_o",    irq_maj_o,    p_maj);
      chk("R5/R12", "done_o",    done_o,       m_done);
      chk("R6",  "req_dis_o",    req_dis_o,    p_dis);
      chk("R7",  "link_start_o", link_start_o, p_link);
      if (p_link) chk("R7", "link_ch_o", link_ch_o, p_lch);
      chk("R8",  "sg_req_o",     sg_req_o,     m_req);
      if (m_req) chk("R8", "sg_addr_o", sg_addr_o, m_addr);
      chk("R9",  "sg_err_o",     sg_err_o,     m_err);
      chk("R10", "start_go_o",   start_go_o,   m_start && !eng_busy_i);
      chk("R11", "en_link_o",    en_link_o,    m_el);
      chk("R11", "en_sg_o",      en_sg_o,      m_es);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] cword(bit st, bit im, bit ih, bit dr, bit es, bit el, int lch);
    logic [31:0] w = '0;
    w[0] = st; w[1] = im; w[2] = ih; w[3] = dr; w[4] = es; w[5] = el;
    w[13:8] = lch[5:0];
    return w;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic act(input int n);
    for (int i = 0; i < n; i++) begin
      act_i = 1; tick();
    end
    act_i = 0;
  endtask

  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic realign();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    #800000;
    if (!finished) begin
      finished = 1;
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; act_i = 0;
    eng_busy_i = 0; link_in_i = 0; sg_ack_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    to_neg();
    chk("R1", "done_o", done_o, 0);
    chk("R1", "citer_o", citer_o, 1);
    chk("R1", "strobes", {irq_half_o, irq_maj_o, req_dis_o, link_start_o, start_go_o, sg_err_o}, 0);
    chk("R1", "sg_req_o", sg_req_o, 0);
    chk("R1", "enables", {en_link_o, en_sg_o}, 0);
    realign();

    // R4 halfway on begin count 4 (fires when count drops to 2)
    wr(2'd1, 32'd4);
    wr(2'd0, cword(0, 1, 1, 0, 0, 0, 0));
    act(2);
    to_neg();
    chk("R4", "irq_half_o at count 2", irq_half_o, 1);
    chk("R3", "citer_o after two acts", citer_o, 2);
    realign();
    act(2);
    to_neg();
    chk("R5", "irq_maj_o at zero", irq_maj_o, 1);
    chk("R5", "citer_o reloaded", citer_o, 4);
    chk("R5", "done_o", done_o, 1);
    realign();

    // R4 single-iteration corner: half and completion together
    wr(2'd1, 32'd1);
    act(1);
    to_neg();
    chk("R4", "irq_half_o begin=1", irq_half_o, 1);
    chk("R5", "irq_maj_o begin=1", irq_maj_o, 1);
    realign();

    // R2 zero begin count behaves as one
    wr(2'd1, 32'd0);
    to_neg();
    chk("R2", "citer_o for zero write", citer_o, 1);
    chk("R2", "done_o cleared", done_o, 0);
    realign();

    // R6 / R7 request disable and link
    wr(2'd1, 32'd3);
    wr(2'd0, cword(0, 0, 0, 1, 0, 1, 37));
    act(3);
    to_neg();
    chk("R6", "req_dis_o", req_dis_o, 1);
    chk("R7", "link_start_o", link_start_o, 1);
    chk("R7", "link_ch_o", link_ch_o, 37);
    realign();
    to_neg();
    chk("R7", "link_start_o single pulse", link_start_o, 0);
    realign();

    // R8 aligned reload, held until acknowledged
    wr(2'd2, 32'h1000_0040);
    wr(2'd1, 32'd2);
    wr(2'd0, cword(0, 0, 0, 0, 1, 0, 0));
    act(2);
    repeat (3) tick();
    to_neg();
    chk("R8", "sg_req_o held", sg_req_o, 1);
    chk("R8", "sg_addr_o", sg_addr_o, 32'h1000_0040);
    realign();
    sg_ack_i = 1; tick(); sg_ack_i = 0;
    to_neg();
    chk("R8", "sg_req_o after ack", sg_req_o, 0);
    realign();

    // R9 misaligned pointer
    wr(2'd2, 32'h1000_0044);
    wr(2'd1, 32'd1);
    wr(2'd0, cword(0, 0, 0, 0, 1, 0, 0));
    act(1);
    to_neg();
    chk("R9", "sg_err_o", sg_err_o, 1);
    chk("R9", "sg_req_o stays low", sg_req_o, 0);
    realign();

    // R10 start held off by busy, then go; link also starts
    eng_busy_i = 1;
    wr(2'd0, cword(1, 0, 0, 0, 0, 0, 0));
    to_neg();
    chk("R10", "start_go_o while busy", start_go_o, 0);
    realign();
    eng_busy_i = 0;
    to_neg();
    chk("R10", "start_go_o when idle", start_go_o, 1);
    realign();
    to_neg();
    chk("R10", "start_go_o cleared", start_go_o, 0);
    chk("R10", "go cleared done", done_o, 0);
    realign();
    link_in_i = 1; tick(); link_in_i = 0;
    to_neg();
    chk("R10", "start_go_o from link", start_go_o, 1);
    realign();

    // R11 control write in completion cycle stores, next one is masked
    wr(2'd1, 32'd1);
    wr(2'd0, cword(0, 0, 0, 0, 0, 1, 5));
    act_i = 1; wr_en = 1; wr_sel = 2'd0; wr_data = cword(0, 0, 0, 0, 1, 1, 9);
    tick();
    act_i = 0; wr_en = 0;
    to_neg();
    chk("R11", "en_link_o written with completion", en_link_o, 1);
    chk("R11", "en_sg_o written with completion", en_sg_o, 1);
    chk("R7", "link_ch_o uses old field", link_ch_o, 5);
    realign();
    wr(2'd0, cword(0, 0, 0, 0, 1, 1, 9));
    to_neg();
    chk("R11", "en_link_o masked while done", en_link_o, 0);
    chk("R11", "en_sg_o masked while done", en_sg_o, 0);
    realign();

    // R12 activation clears done; R2 count write beats activation
    wr(2'd1, 32'd2);
    act(2);
    to_neg();
    chk("R12", "done set before", done_o, 1);
    realign();
    act(1);
    to_neg();
    chk("R12", "done cleared by activation", done_o, 0);
    chk("R3", "citer_o", citer_o, 1);
    realign();
    act_i = 1; wr_en = 1; wr_sel = 2'd1; wr_data = 32'd5;
    tick();
    act_i = 0; wr_en = 0;
    to_neg();
    chk("R2", "citer_o after write with act", citer_o, 5);
    chk("R2", "no completion", irq_maj_o, 0);
    realign();

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      wr_en = (r < 12);
      wr_sel = 2'($urandom_range(0, 3));
      if (wr_sel == 2'd1) wr_data = $urandom_range(0, 6);
      else if (wr_sel == 2'd2) wr_data = ($urandom_range(0, 1) == 1) ? ($urandom & 32'hFFFF_FFE0) : $urandom;
      else wr_data = $urandom;
      act_i      = ($urandom_range(0, 99) < 35);
      eng_busy_i = ($urandom_range(0, 99) < 40);
      link_in_i  = ($urandom_range(0, 99) < 5);
      sg_ack_i   = ($urandom_range(0, 99) < 20);
      tick();
    end
    wr_en = 0; act_i = 0; eng_busy_i = 0; link_in_i = 0; sg_ack_i = 0;
    repeat (3) tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule